// File: doc/BRIEF.md
# Triple-Redundant Voter with Spare Slot Substitution

This block sits behind three identical copies of a logic module and turns their outputs into one protected bus. Every cycle it forms the bitwise majority of the three active voting slots and registers it. It also reports, per slot, which copy disagreed with that majority, and it keeps a saturating count of cycles in which any disagreement was seen.

A fourth, spare copy is wired in as well. A slot is declared permanently failed in either of two cases: it dissents for `HARD_N` consecutive cycles, or the `fail_mark` control input flags it. The block then raises a repair request and drops the failed slot from the vote. While the spare is being loaded, the voter compares the two remaining copies and flags any mismatch between them. Loading the spare is outside this block and appears only as the request and acknowledge handshake. When the acknowledge arrives, the spare is mapped into the failed slot and three-way voting resumes. Only one substitution is possible. A second permanent failure leaves the block in a terminal two-copy mode with an unrecoverable flag, which lasts until reset.

Top module: `tmr_spare_voter`

## Requirements
- R1: After reset, `voted`, `err_flag`, `fault_cnt` and `mismatch` are zero, and `repair_req`, `spare_used` and `unrecoverable` are low.
- R2: In three-way mode, `voted` equals the bitwise majority of the three active slots sampled at the previous rising edge, which is one cycle of latency.
- R3: In three-way mode, `err_flag` bit i (bit 0 = slot 0, bit 1 = slot 1, bit 2 = slot 2) is set, with the same latency as `voted`, when slot i differs from the majority.
- R4: `fault_cnt` increments once for each cycle in which any slot dissents or a two-copy mismatch occurs, and it holds at all ones.
- R5: A slot that dissents for fewer than `HARD_N` consecutive cycles and then agrees causes no repair request.
- R6: When a slot dissents for the `HARD_N`-th consecutive cycle, or when its `fail_mark` bit is high in three-way mode, `repair_req` is high after that edge. If several slots are hit at once, the lowest index wins.
- R7: While `repair_req` is high, the failed slot is excluded. `voted` takes the lower-indexed remaining slot, `mismatch` is set when the two remaining slots differ, and `err_flag` reads zero.
- R8: `repair_ack` is acted on only while `repair_req` is high. It then clears `repair_req` and sets `spare_used`, after which `spare_copy` takes the place of `copy` i in slot i. At any other time `repair_ack` has no effect.
- R9: With the spare in use, the spare votes in the failed slot, and its dissent is reported on that slot's `err_flag` bit.
- R10: A permanent failure of any slot while the spare is in use sets `unrecoverable`. That slot is excluded under the two-copy rules of R7. The state stays until reset, and further `fail_mark` or `repair_ack` inputs are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| copy0 | input | W | Output of redundant copy 0 |
| copy1 | input | W | Output of redundant copy 1 |
| copy2 | input | W | Output of redundant copy 2 |
| spare_copy | input | W | Output of the spare copy |
| fail_mark | input | 3 | Declares slot i permanently failed (bit i) |
| repair_ack | input | 1 | Spare has been loaded |
| voted | output | W | Registered protected output |
| err_flag | output | 3 | Per-slot dissent flags, registered |
| fault_cnt | output | CNT_W | Saturating disagreement counter |
| mismatch | output | 1 | Two-copy comparison differs |
| repair_req | output | 1 | Spare load requested; failed slot excluded |
| spare_used | output | 1 | Spare is mapped into a voting slot |
| unrecoverable | output | 1 | Second permanent failure seen |

## Verification
The bench builds the block with `W=8`, `HARD_N=3` and `CNT_W=4`. A threshold of three brings both the transient case (two dissents) and the permanent case (three dissents) within a few cycles. A four-bit counter lets a short run of alternating dissents drive `fault_cnt` to its saturation value of 15. Together these settings reach the whole path from normal voting through loading, spare substitution and the terminal degraded mode in a single run.

// File: rtl/tmr_spare_voter.sv
module tmr_spare_voter #(
  parameter int W      = 32,
  parameter int HARD_N = 4,
  parameter int CNT_W  = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [W-1:0]     copy0,
  input  logic [W-1:0]     copy1,
  input  logic [W-1:0]     copy2,
  input  logic [W-1:0]     spare_copy,
  input  logic [2:0]       fail_mark,
  input  logic             repair_ack,
  output logic [W-1:0]     voted,
  output logic [2:0]       err_flag,
  output logic [CNT_W-1:0] fault_cnt,
  output logic             mismatch,
  output logic             repair_req,
  output logic             spare_used,
  output logic             unrecoverable
);

  localparam int SW = $clog2(HARD_N + 1);
  localparam logic [SW-1:0] LAST = SW'(HARD_N - 1);

  typedef enum logic [1:0] {M_TRI, M_LOAD, M_SPARE, M_DEG} mode_t;

  mode_t        mode;
  logic [1:0]   map_slot, dead_slot;
  logic [SW-1:0] streak [3];

  logic [W-1:0] s [3];
  logic [W-1:0] maj, pa, pb, vote_c;
  logic [2:0]   err_c, hit;
  logic [1:0]   excl, hit_idx;
  logic         tri_m, mm_c;

  assign repair_req    = (mode == M_LOAD);
  assign spare_used    = (mode == M_SPARE) || (mode == M_DEG);
  assign unrecoverable = (mode == M_DEG);
  assign tri_m         = (mode == M_TRI) || (mode == M_SPARE);
  assign excl          = (mode == M_LOAD) ? map_slot : dead_slot;

  assign s[0] = (spare_used && map_slot == 2'd0) ? spare_copy : copy0;
  assign s[1] = (spare_used && map_slot == 2'd1) ? spare_copy : copy1;
  assign s[2] = (spare_used && map_slot == 2'd2) ? spare_copy : copy2;

  assign maj = (s[0] & s[1]) | (s[0] & s[2]) | (s[1] & s[2]);

  always_comb begin
    pa = (excl == 2'd0) ? s[1] : s[0];
    pb = (excl == 2'd2) ? s[1] : s[2];
  end

  assign vote_c = tri_m ? maj : pa;
  assign mm_c   = !tri_m && (pa != pb);

  always_comb begin
    for (int i = 0; i < 3; i++) begin
      err_c[i] = tri_m && (s[i] != maj);
      hit[i]   = tri_m && ((err_c[i] && streak[i] == LAST) || fail_mark[i]);
    end
    hit_idx = 2'd0;
    for (int i = 2; i >= 0; i--)
      if (hit[i]) hit_idx = 2'(i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      voted     <= '0;
      err_flag  <= '0;
      mismatch  <= 1'b0;
      fault_cnt <= '0;
      mode      <= M_TRI;
      map_slot  <= 2'd0;
      dead_slot <= 2'd0;
      for (int i = 0; i < 3; i++) streak[i] <= '0;
    end else begin
      voted    <= vote_c;
      err_flag <= err_c;
      mismatch <= mm_c;
      if ((|err_c || mm_c) && fault_cnt != {CNT_W{1'b1}})
        fault_cnt <= fault_cnt + 1'b1;
      for (int i = 0; i < 3; i++)
        streak[i] <= (err_c[i] && streak[i] != LAST) ? streak[i] + 1'b1 : '0;
      unique case (mode)
        M_TRI:   if (|hit) begin mode <= M_LOAD; map_slot <= hit_idx; end
        M_LOAD:  if (repair_ack) mode <= M_SPARE;
        M_SPARE: if (|hit) begin mode <= M_DEG; dead_slot <= hit_idx; end
        default: mode <= M_DEG;
      endcase
    end
  end

  a_r8_map_on_ack: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(spare_used) |-> $past(repair_ack) && $past(repair_req));
  a_r8_req_drops: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(spare_used) |-> !repair_req);
  a_r7_quiet_flags: assert property (@(posedge clk) disable iff (!rst_n)
    repair_req && $past(repair_req) |-> err_flag == 3'b000);
  a_r10_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    unrecoverable |=> unrecoverable && spare_used);
  a_r4_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    fault_cnt >= $past(fault_cnt));
  a_r7_mm_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    mismatch |-> err_flag == 3'b000);

endmodule

// File: tb/sim_tmr_spare_voter.sv
module sim_tmr_spare_voter;
  localparam int W = 8, N = 3, CW = 4;

  logic clk = 0, rst_n = 0;
  logic [W-1:0] c0 = 0, c1 = 0, c2 = 0, sp = 0;
  logic [2:0] mark = 0;
  logic ack = 0;
  logic [W-1:0] voted;
  logic [2:0] err_flag;
  logic [CW-1:0] fault_cnt;
  logic mismatch, repair_req, spare_used, unrecoverable;
  int total = 0, bad = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  tmr_spare_voter #(.W(W), .HARD_N(N), .CNT_W(CW)) u0 (
    .clk(clk), .rst_n(rst_n), .copy0(c0), .copy1(c1), .copy2(c2),
    .spare_copy(sp), .fail_mark(mark), .repair_ack(ack),
    .voted(voted), .err_flag(err_flag), .fault_cnt(fault_cnt),
    .mismatch(mismatch), .repair_req(repair_req), .spare_used(spare_used),
    .unrecoverable(unrecoverable));

  // {copy0, copy1, copy2, expected voted, expected err_flag}
  localparam logic [39:0] TBL [6] = '{
    {8'h00, 8'h00, 8'h00, 8'h00, 8'h00},
    {8'hAA, 8'hAA, 8'h55, 8'hAA, 8'h04},
    {8'hF0, 8'h0F, 8'hF0, 8'hF0, 8'h02},
    {8'h12, 8'h34, 8'h34, 8'h34, 8'h01},
    {8'h0F, 8'h33, 8'h55, 8'h17, 8'h07},
    {8'h77, 8'h77, 8'h77, 8'h77, 8'h00}
  };

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic step(logic [W-1:0] a, logic [W-1:0] b, logic [W-1:0] c,
                      logic [W-1:0] s, logic k, logic [2:0] m);
    c0 = a; c1 = b; c2 = c; sp = s; ack = k; mark = m;
    @(posedge clk); #1;
    ack = 0; mark = 0;
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    #400000;
    bad++; total++;
    $display("FAIL watchdog act=hung exp=done");
    summary();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    chk("R1 voted", voted, 0);
    chk("R1 err", err_flag, 0);
    chk("R1 cnt", fault_cnt, 0);
    chk("R1 flags", {mismatch, repair_req, spare_used, unrecoverable}, 0);

    for (int i = 0; i < 6; i++) begin
      step(TBL[i][39:32], TBL[i][31:24], TBL[i][23:16], 8'h00, 0, 0);
      chk("R2 voted", voted, TBL[i][15:8]);
      chk("R3 err", err_flag, TBL[i][2:0]);
    end
    chk("R4 count", fault_cnt, 4);

    for (int i = 0; i < 20; i++)
      step((i % 2) ? 8'h01 : 8'h00, (i % 2) ? 8'h00 : 8'h01, 8'h00, 8'h00, 0, 0);
    chk("R4 saturate", fault_cnt, 15);
    chk("R5 no req alt", repair_req, 0);

    step(8'h21, 8'h21, 8'h21, 8'h00, 1, 0);
    chk("R8 ack ignored", {repair_req, spare_used}, 0);

    step(8'h21, 8'h99, 8'h21, 8'h00, 0, 0);
    step(8'h21, 8'h99, 8'h21, 8'h00, 0, 0);
    step(8'h21, 8'h21, 8'h21, 8'h00, 0, 0);
    chk("R5 transient", repair_req, 0);

    step(8'h21, 8'h98, 8'h21, 8'h00, 0, 0);
    step(8'h21, 8'h98, 8'h21, 8'h00, 0, 0);
    chk("R6 before N", repair_req, 0);
    step(8'h21, 8'h98, 8'h21, 8'h00, 0, 0);
    chk("R6 req", repair_req, 1);
    chk("R6 vote", voted, 8'h21);

    step(8'h5A, 8'h00, 8'h5A, 8'h99, 0, 0);
    chk("R7 vote", voted, 8'h5A);
    chk("R7 mm clear", mismatch, 0);
    chk("R7 err zero", err_flag, 0);
    chk("R8 no map yet", spare_used, 0);
    step(8'h5A, 8'h00, 8'h5B, 8'h99, 0, 0);
    chk("R7 mm set", mismatch, 1);
    chk("R7 lower slot", voted, 8'h5A);

    step(8'h11, 8'hEE, 8'h11, 8'h22, 1, 0);
    chk("R8 mapped", {repair_req, spare_used}, 2'b01);
    step(8'h11, 8'hEE, 8'h11, 8'h22, 0, 0);
    chk("R9 vote", voted, 8'h11);
    chk("R9 spare dissent", err_flag, 3'b010);
    step(8'h44, 8'hEE, 8'h00, 8'h44, 0, 0);
    chk("R9 spare majority", voted, 8'h44);
    chk("R9 err slot2", err_flag, 3'b100);
    step(8'h11, 8'h11, 8'h11, 8'h11, 1, 0);
    chk("R8 ack in spare", {repair_req, spare_used, unrecoverable}, 3'b010);

    step(8'h11, 8'h11, 8'h11, 8'h11, 0, 3'b001);
    chk("R10 unrec", {repair_req, spare_used, unrecoverable}, 3'b011);
    step(8'hFF, 8'h00, 8'hC3, 8'h3C, 0, 0);
    chk("R10 vote", voted, 8'h3C);
    chk("R10 mm", mismatch, 1);
    chk("R10 err", err_flag, 0);
    step(8'hFF, 8'h00, 8'h3C, 8'h3C, 1, 3'b111);
    chk("R10 persists", {repair_req, spare_used, unrecoverable}, 3'b011);
    chk("R10 agree", {voted, 1'b0, mismatch}, {8'h3C, 2'b00});

    summary();
  end
endmodule